// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns single read and write requests from the on-chip side into timed cycles on an external memory bus. A requester presents a halfword address, byte enables, a write flag and write data, holds `req` high, and waits for a one-clock `ack`. The block then runs an address phase marked by `ale`, an optional gap, and a strobe phase in which `bus_rd`, `bus_wrl` or `bus_wrh` is high. It returns read data on `rdata` together with `ack`.

The bus has four shapes, set by `cfg_mux` and `cfg_wide`. With a 16-bit data path, every access takes one beat. With an 8-bit data path, a full-word access is split into two byte beats, low byte first. In demultiplexed operation, `ea_addr` carries the address for the whole access and `ad_out`/`ad_in` carry only data. In multiplexed operation, the address is placed on `ad_out` while `ale` is high, and the shared lanes move on to data only after `ale` has fallen.

Several timing and width settings are programmable: the number of segment lines driven, the number of wait states, a stretched address phase, a read/write strobe delay, a tri-state turnaround after reads, and ready-driven stretching of the strobe. The configuration inputs must stay constant while an access is in progress.

Top module: `ext_bus_ctrl`

## Requirements
- R1: With `cfg_mux`=0, the full low address appears on `ea_addr` during `ale`, and `ad_out` drives only write data, during the gap and strobe phases (`ad_oe`=00 on reads). With `cfg_mux`=1, the address appears on `ad_out` with `ad_oe`=11 while `ale` is high, and `ea_addr` stays 0.
- R2: With `cfg_mux`=1 and `cfg_wide`=0, `ad_out[15:8]` carries address bits 15..8 with `ad_oe[1]`=1 for the whole access. The low lane carries the address during `ale`, then write data with `ad_oe[0]`=1, or nothing on a read.
- R3: `ea_seg` drives address bits 23..16 masked by `cfg_seg_sel`: 0 drives no lines, 1 drives bits 17..16, 2 drives bits 19..16, and 3 drives all eight. Lines that are not driven stay 0.
- R4: With `cfg_rdy_en`=1, the strobe is stretched by one cycle for each cycle `ready` is high once the programmed wait states are used up. With `cfg_rdy_en`=0, `ready` has no effect.
- R5: Each strobe lasts `cfg_wait`+1 cycles when it is not stretched by `ready`.
- R6: `ale` lasts 1 cycle, or 2 when `cfg_ale_long`=1. The strobe starts `cfg_rw_delay` cycles after `ale` falls. With `cfg_tri`=1, a read strobe is followed by one cycle with no `ale` and no strobe before the next beat's address phase or the next access.
- R7: Write strobes. With `cfg_lane_wr`=0, `bus_wrl` is high for every write and `bus_wrh` is never high. With `cfg_lane_wr`=1 and `cfg_wide`=1, `bus_wrl` follows `req_be[0]` and `bus_wrh` follows `req_be[1]`. With `cfg_lane_wr`=1 and `cfg_wide`=0, `bus_wrl` is high on every write beat.
- R8: `bus_rd` is high during the strobe of every read beat and never at the same time as a write strobe.
- R9: The bus byte address is `{req_waddr, x}`. With `cfg_wide`=1 there is one beat, and x=1 only for `req_be`=10. With `cfg_wide`=0, `req_be`=11 gives two beats (x=0, then x=1), and a single-byte enable gives one beat with x=`req_be[1]`. `req_be` must be nonzero.
- R10: `ack` is high for exactly the one cycle after the final strobe ends. At that cycle `rdata` holds each enabled byte lane read, and 0 in lanes that are not enabled. On an 8-bit bus, each byte is taken from `ad_in[7:0]`.
- R11: No strobe is ever high while `ale` is high.
- R12: After reset, `ack`, `ale`, all strobes, `ad_oe`, `ea_addr`, `ea_seg` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mux | input | 1 | 1 = shared address/data lanes |
| cfg_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| cfg_seg_sel | input | 2 | Segment line count select |
| cfg_lane_wr | input | 1 | 1 = per-lane write strobes |
| cfg_rdy_en | input | 1 | Enable ready stretching |
| cfg_wait | input | WAIT_W | Wait states per strobe |
| cfg_ale_long | input | 1 | Two-cycle address phase |
| cfg_rw_delay | input | 1 | One-cycle gap before strobe |
| cfg_tri | input | 1 | Turnaround cycle after reads |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write |
| req_waddr | input | ADDR_W-1 | Halfword address |
| req_be | input | 2 | Byte enables |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data |
| ea_addr | output | 16 | Dedicated address lanes |
| ea_seg | output | ADDR_W-16 | Segment address lines |
| ad_out | output | 16 | Data or shared address/data out |
| ad_oe | output | 2 | Per-lane output enable |
| ad_in | input | 16 | Data in |
| ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read strobe |
| bus_wrl | output | 1 | Low or global write strobe |
| bus_wrh | output | 1 | High write strobe |
| ready | input | 1 | High = insert wait state |

## Verification
The bench acts as a byte-wide memory on the bus and as a cycle monitor. It checks every address phase, strobe and acknowledge against expectations it computes from the configuration and the request.

Directed accesses cover each of the four bus shapes with word, low-byte and high-byte writes and read-backs. These separate the one-beat and two-beat splitting and show which lane each byte moves on. Further directed cases cover the four segment widths with all-ones high address bits, which exposes any line that should be masked. Ready is held for more cycles than, fewer cycles than, and zero cycles beyond the wait count, and it is also held high while disabled, which separates stretching from ignoring. Random accesses then mix all timing knobs, so that the turnaround cycle and the strobe delay are checked between the beats of a split word.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_EXT = 3'd2,
        ST_GAP      = 3'd3,
        ST_STROBE   = 3'd4,
        ST_TURN     = 3'd5
    } ebc_state_e;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

endpackage

// File: rtl/ebc_seg_mask.sv
module ebc_seg_mask #(
    parameter int SEG_W = 8
) (
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic [SEG_W-1:0] seg_in,
    output logic [SEG_W-1:0] seg_out
);

    // sel: 0 -> none, 1 -> two lines, 2 -> four lines, 3 -> all lines
    for (genvar i = 0; i < SEG_W; i++) begin : g_line
        logic keep;
        assign keep       = (sel == 2'd3) || ((sel == 2'd2) && (i < 4)) || ((sel == 2'd1) && (i < 2));
        assign seg_out[i] = en & keep & seg_in[i];
    end

endmodule

// File: rtl/ebc_timing.sv
module ebc_timing
    import ebc_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              two_beats,
    input  logic              req_rd,
    input  logic              cfg_ale_long,
    input  logic              cfg_rw_delay,
    input  logic              cfg_tri,
    input  logic              cfg_rdy_en,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              ready,
    output logic              accept,
    output logic              busy,
    output logic              ale,
    output logic              strobe,
    output logic              data_phase,
    output logic              capture,
    output logic              beat,
    output logic              ack
);

    typedef struct packed {
        ebc_state_e        st;
        logic [WAIT_W-1:0] wcnt;
        logic              beat;
        logic              two;
        logic              rd;
        logic              ack;
    } tstate_t;

    tstate_t s_q, s_d;
    logic    last_beat;
    logic    hold;

    assign last_beat = !s_q.two || s_q.beat;
    assign hold      = cfg_rdy_en && ready;
    assign accept    = (s_q.st == ST_IDLE) && req && !s_q.ack;
    assign capture   = (s_q.st == ST_STROBE) && (s_q.wcnt == '0) && !hold;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    s_d.st   = ST_ADDR;
                    s_d.beat = 1'b0;
                    s_d.two  = two_beats;
                    s_d.rd   = req_rd;
                end
            end
            ST_ADDR: begin
                s_d.wcnt = cfg_wait;
                if (cfg_ale_long)      s_d.st = ST_ADDR_EXT;
                else if (cfg_rw_delay) s_d.st = ST_GAP;
                else                   s_d.st = ST_STROBE;
            end
            ST_ADDR_EXT: begin
                s_d.wcnt = cfg_wait;
                s_d.st   = cfg_rw_delay ? ST_GAP : ST_STROBE;
            end
            ST_GAP: begin
                s_d.wcnt = cfg_wait;
                s_d.st   = ST_STROBE;
            end
            ST_STROBE: begin
                if (s_q.wcnt != '0) begin
                    s_d.wcnt = s_q.wcnt - 1'b1;
                end else if (!hold) begin
                    s_d.ack = last_beat;
                    if (s_q.rd && cfg_tri) begin
                        s_d.st = ST_TURN;
                    end else if (last_beat) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st   = ST_ADDR;
                        s_d.beat = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (last_beat) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.st   = ST_ADDR;
                    s_d.beat = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign ale        = (s_q.st == ST_ADDR) || (s_q.st == ST_ADDR_EXT);
    assign strobe     = (s_q.st == ST_STROBE);
    assign data_phase = (s_q.st == ST_GAP) || (s_q.st == ST_STROBE);
    assign beat       = s_q.beat;
    assign ack        = s_q.ack;

    p_ale_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && strobe));

    p_wait_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && s_q.wcnt != '0) |=> (strobe && $stable(beat)));

    p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && s_q.wcnt == '0 && cfg_rdy_en && ready) |=> strobe);

    p_ready_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && s_q.wcnt == '0 && !cfg_rdy_en) |=> !strobe);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(strobe));

endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_we,
    input  logic [ADDR_W-1:1] req_waddr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_mux,
    input  logic              cfg_wide,
    input  logic              cfg_lane_wr,
    input  logic              busy,
    input  logic              ale,
    input  logic              strobe,
    input  logic              data_phase,
    input  logic              capture,
    input  logic              beat,
    input  logic [DATA_W-1:0] ad_in,
    output logic              two_beats,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] ad_out,
    output logic [LANES-1:0]  ad_oe,
    output logic              bus_rd,
    output logic              bus_wrl,
    output logic              bus_wrh,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [ADDR_W-1:1] wa;
        logic [LANES-1:0]  be;
        logic              we;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
    } dstate_t;

    dstate_t           s_q, s_d;
    logic              lane;
    logic [LANE_W-1:0] wbyte;
    logic              wr_any;

    assign two_beats = !cfg_wide && (req_be == 2'b11);
    assign lane      = cfg_wide ? 1'b0 : ((s_q.be == 2'b11) ? beat : s_q.be[1]);
    assign bus_addr  = {s_q.wa, (cfg_wide ? (s_q.be == 2'b10) : lane)};
    assign wbyte     = lane ? s_q.wd[15:8] : s_q.wd[7:0];

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.wa = req_waddr;
            s_d.be = req_be;
            s_d.we = req_we;
            s_d.wd = req_wdata;
            s_d.rd = '0;
        end else if (capture && !s_q.we) begin
            for (int b = 0; b < LANES; b++) begin
                if (cfg_wide ? s_q.be[b] : (lane == b[0]))
                    s_d.rd[b*LANE_W +: LANE_W] = cfg_wide ? ad_in[b*LANE_W +: LANE_W] : ad_in[LANE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = '0;
        if (busy) begin
            if (cfg_mux && ale) begin
                ad_out = bus_addr[DATA_W-1:0];
                ad_oe  = '1;
            end else begin
                if (cfg_mux && !cfg_wide) begin
                    ad_out[15:8] = bus_addr[15:8];
                    ad_oe[1]     = 1'b1;
                end
                if (data_phase && s_q.we) begin
                    if (cfg_wide) begin
                        ad_out = s_q.wd;
                        ad_oe  = '1;
                    end else begin
                        ad_out[7:0] = wbyte;
                        ad_oe[0]    = 1'b1;
                    end
                end
            end
        end
    end

    assign wr_any  = strobe && s_q.we;
    assign bus_rd  = strobe && !s_q.we;
    assign bus_wrl = wr_any && (!(cfg_lane_wr && cfg_wide) || s_q.be[0]);
    assign bus_wrh = wr_any && cfg_lane_wr && cfg_wide && s_q.be[1];
    assign rdata   = s_q.rd;

    p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && (bus_wrl || bus_wrh)));

    p_global_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_lane_wr |-> !bus_wrh);

    p_mux_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mux && ale) |-> (ad_oe == 2'b11));

    p_mux8_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mux && !cfg_wide && busy) |-> (ad_oe[1] && ad_out[15:8] == bus_addr[15:8]));

    p_read_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !(cfg_mux && !cfg_wide)) |-> (ad_oe == 2'b00));

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_mux,
    input  logic               cfg_wide,
    input  logic [1:0]         cfg_seg_sel,
    input  logic               cfg_lane_wr,
    input  logic               cfg_rdy_en,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic               cfg_ale_long,
    input  logic               cfg_rw_delay,
    input  logic               cfg_tri,
    input  logic               req,
    input  logic               req_we,
    input  logic [ADDR_W-1:1]  req_waddr,
    input  logic [1:0]         req_be,
    input  logic [15:0]        req_wdata,
    output logic               ack,
    output logic [15:0]        rdata,
    output logic [15:0]        ea_addr,
    output logic [ADDR_W-17:0] ea_seg,
    output logic [15:0]        ad_out,
    output logic [1:0]         ad_oe,
    input  logic [15:0]        ad_in,
    output logic               ale,
    output logic               bus_rd,
    output logic               bus_wrl,
    output logic               bus_wrh,
    input  logic               ready
);

    localparam int SEG_W = ADDR_W - 16;

    logic              accept, busy, strobe, data_phase, capture, beat, two_beats;
    logic [ADDR_W-1:0] bus_addr;

    ebc_timing #(.WAIT_W(WAIT_W)) u_timing (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .two_beats    (two_beats),
        .req_rd       (!req_we),
        .cfg_ale_long (cfg_ale_long),
        .cfg_rw_delay (cfg_rw_delay),
        .cfg_tri      (cfg_tri),
        .cfg_rdy_en   (cfg_rdy_en),
        .cfg_wait     (cfg_wait),
        .ready        (ready),
        .accept       (accept),
        .busy         (busy),
        .ale          (ale),
        .strobe       (strobe),
        .data_phase   (data_phase),
        .capture      (capture),
        .beat         (beat),
        .ack          (ack)
    );

    ebc_datapath #(.ADDR_W(ADDR_W)) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_we      (req_we),
        .req_waddr   (req_waddr),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .cfg_mux     (cfg_mux),
        .cfg_wide    (cfg_wide),
        .cfg_lane_wr (cfg_lane_wr),
        .busy        (busy),
        .ale         (ale),
        .strobe      (strobe),
        .data_phase  (data_phase),
        .capture     (capture),
        .beat        (beat),
        .ad_in       (ad_in),
        .two_beats   (two_beats),
        .bus_addr    (bus_addr),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .bus_rd      (bus_rd),
        .bus_wrl     (bus_wrl),
        .bus_wrh     (bus_wrh),
        .rdata       (rdata)
    );

    ebc_seg_mask #(.SEG_W(SEG_W)) u_seg (
        .en      (busy),
        .sel     (cfg_seg_sel),
        .seg_in  (bus_addr[ADDR_W-1:16]),
        .seg_out (ea_seg)
    );

    assign ea_addr = (busy && !cfg_mux) ? bus_addr[15:0] : 16'h0000;

endmodule

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;

    logic        clk = 0, rst_n = 0;
    logic        cfg_mux = 0, cfg_wide = 1, cfg_lane_wr = 1, cfg_rdy_en = 0;
    logic [1:0]  cfg_seg_sel = 3;
    logic [3:0]  cfg_wait = 0;
    logic        cfg_ale_long = 0, cfg_rw_delay = 0, cfg_tri = 0;
    logic        req = 0, req_we = 0;
    logic [23:1] req_waddr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata, ea_addr, ad_out, ad_in;
    logic [7:0]  ea_seg;
    logic [1:0]  ad_oe;
    logic        ale, bus_rd, bus_wrl, bus_wrh;
    logic        ready = 0;

    ext_bus_ctrl uut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    logic [7:0]  mem [256];
    logic [23:0] ba = '0;
    int  nb = 1, bi = 0, rk = 0;
    int  alen = 0, scnt = 0, dcnt = 0, gcnt = 0;
    logic after_ale = 0, p_ale = 0, p_strb = 0, running = 0, hung = 0;
    logic [15:0] exp_rd;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [7:0] seg_f(input logic [7:0] s, input logic [1:0] sel);
        case (sel)
            2'd0: return 8'h00;
            2'd1: return s & 8'h03;
            2'd2: return s & 8'h0F;
            default: return s;
        endcase
    endfunction

    function automatic logic [23:0] beat_addr(input logic [23:1] wa, input logic [1:0] be, input logic wide, input int j);
        if (wide)            return {wa, be == 2'b10};
        else if (be == 2'b11) return {wa, j[0]};
        else                  return {wa, be[1]};
    endfunction

    always_comb begin
        if (cfg_wide) ad_in = {mem[{ba[7:1], 1'b1}], mem[{ba[7:1], 1'b0}]};
        else          ad_in = {8'hA5, mem[ba[7:0]]};
    end

    // bus monitor and memory model
    always @(negedge clk) begin
        logic strb, ack_exp;
        logic [23:0] ea, got;
        strb = bus_rd | bus_wrl | bus_wrh;
        if (rst_n && running) begin
            if (p_strb && !strb) begin
                chk(scnt == ((cfg_rdy_en ? ((rk > cfg_wait) ? rk : int'(cfg_wait)) : int'(cfg_wait)) + 1),
                    "R4/R5 strobe length", scnt, cfg_wait);
                gcnt = 0;
            end
            ack_exp = p_strb && !strb && (bi == nb);
            if (ack || ack_exp) chk(ack == ack_exp, "R10 ack timing", ack, ack_exp);
            if (ale) begin
                chk(!strb, "R11 strobe during ale", strb, 0);
                if (!p_ale) begin
                    if (bi > 0) chk(gcnt == ((cfg_tri && !req_we) ? 1 : 0), "R6 turnaround", gcnt, cfg_tri);
                    bi++;
                    alen = 1;
                end else alen++;
                ea  = beat_addr(req_waddr, req_be, cfg_wide, bi - 1);
                got = cfg_mux ? {ea_seg, ad_out} : {ea_seg, ea_addr};
                chk(got == {seg_f(ea[23:16], cfg_seg_sel), ea[15:0]}, "R1/R3/R9 address", got, ea);
                if (cfg_mux) chk(ad_oe == 2'b11 && ea_addr == 0, "R1 mux addr drive", {ad_oe, ea_addr}, 2'b11);
                ba = got;
            end else begin
                if (p_ale) begin
                    chk(alen == 1 + int'(cfg_ale_long), "R6 ale length", alen, cfg_ale_long);
                    after_ale = 1;
                    dcnt = 0;
                end
                if (!strb && bi > 0 && !after_ale) gcnt++;
            end
            if (after_ale && !strb && !ale) dcnt++;
            if (strb && !p_strb) begin
                chk(dcnt == int'(cfg_rw_delay), "R6 strobe delay", dcnt, cfg_rw_delay);
                after_ale = 0;
                scnt = 1;
            end else if (strb) scnt++;
            if (strb) begin
                if (req_we) begin
                    logic ewl, ewh;
                    ewl = !(cfg_lane_wr && cfg_wide) || req_be[0];
                    ewh = cfg_lane_wr && cfg_wide && req_be[1];
                    chk({bus_rd, bus_wrl, bus_wrh} == {1'b0, ewl, ewh}, "R7 write strobes", {bus_rd, bus_wrl, bus_wrh}, {1'b0, ewl, ewh});
                    if (cfg_wide) begin
                        chk(ad_oe == 2'b11 && ad_out == req_wdata, "R1 wide write data", {ad_oe, ad_out}, {2'b11, req_wdata});
                        if (req_be[0]) mem[{ba[7:1], 1'b0}] = ad_out[7:0];
                        if (req_be[1]) mem[{ba[7:1], 1'b1}] = ad_out[15:8];
                    end else begin
                        chk(ad_oe[0] && ad_out[7:0] == (ba[0] ? req_wdata[15:8] : req_wdata[7:0]),
                            "R2 narrow write byte", ad_out[7:0], ba[0] ? req_wdata[15:8] : req_wdata[7:0]);
                        mem[ba[7:0]] = ad_out[7:0];
                    end
                end else begin
                    chk({bus_rd, bus_wrl, bus_wrh} == 3'b100, "R8 read strobe", {bus_rd, bus_wrl, bus_wrh}, 3'b100);
                    chk(ad_oe == ((cfg_mux && !cfg_wide) ? 2'b10 : 2'b00), "R1 read lanes float", ad_oe, 0);
                end
                if (cfg_mux && !cfg_wide)
                    chk(ad_oe[1] && ad_out[15:8] == ba[15:8], "R2 mux8 high lane", ad_out[15:8], ba[15:8]);
                if (!cfg_mux && !cfg_wide) chk(!ad_oe[1], "R1 demux8 high lane", ad_oe, 1);
            end
            if (ack) chk(bi == nb, "R9 beat count", bi, nb);
        end
        p_ale  = ale;
        p_strb = strb;
        ready  = cfg_rdy_en ? (strb && scnt <= rk) : 1'b1;
    end

    task automatic run_txn(input logic we, input logic [23:1] wa, input logic [1:0] be, input logic [15:0] wd, input int k);
        int waited;
        @(negedge clk);
        req_we = we; req_waddr = wa; req_be = be; req_wdata = wd; rk = k;
        nb = (!cfg_wide && be == 2'b11) ? 2 : 1;
        bi = 0;
        exp_rd[7:0]  = be[0] ? mem[{wa[7:1], 1'b0}] : 8'h00;
        exp_rd[15:8] = be[1] ? mem[{wa[7:1], 1'b1}] : 8'h00;
        req = 1;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!ack && waited < 2000);
        if (!ack) begin
            chk(0, "R10 watchdog", waited, 0);
            hung = 1;
        end
        req = 0;
        if (!we) chk(rdata == exp_rd, "R10 read data", rdata, exp_rd);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic mx, input logic wd, input logic lw, input logic [1:0] sg,
                           input logic re, input logic [3:0] wt, input logic al, input logic dl, input logic tr);
        cfg_mux = mx; cfg_wide = wd; cfg_lane_wr = lw; cfg_seg_sel = sg; cfg_rdy_en = re;
        cfg_wait = wt; cfg_ale_long = al; cfg_rw_delay = dl; cfg_tri = tr;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk({ack, ale, bus_rd, bus_wrl, bus_wrh, ad_oe} == 0 && ea_addr == 0 && ea_seg == 0 && rdata == 0,
            "R12 reset outputs", {ack, ale, bus_rd, bus_wrl, bus_wrh, ad_oe}, 0);
        running = 1;
        // demux 16, per-lane strobes
        set_cfg(0, 1, 1, 3, 0, 0, 0, 0, 0);
        run_txn(1, 23'h012340, 2'b11, 16'hBEEF, 0);
        run_txn(0, 23'h012340, 2'b11, 0, 0);
        run_txn(1, 23'h012341, 2'b01, 16'h1122, 0);
        run_txn(1, 23'h012342, 2'b10, 16'h3344, 0);
        run_txn(0, 23'h012341, 2'b10, 0, 0);
        run_txn(0, 23'h012342, 2'b10, 0, 0);
        // mux 16, global strobe
        set_cfg(1, 1, 0, 3, 0, 1, 0, 1, 0);
        run_txn(1, 23'h7FFF10, 2'b10, 16'hA1B2, 0);
        run_txn(0, 23'h7FFF10, 2'b11, 0, 0);
        // mux 8, split word, turnaround, long ale, delay
        set_cfg(1, 0, 1, 2, 0, 0, 1, 1, 1);
        run_txn(1, 23'h555520, 2'b11, 16'hC0DE, 0);
        run_txn(0, 23'h555520, 2'b11, 0, 0);
        run_txn(0, 23'h555521, 2'b10, 0, 0);
        // demux 8, high byte only
        set_cfg(0, 0, 0, 1, 0, 2, 0, 0, 1);
        run_txn(1, 23'h7FFF30, 2'b10, 16'h9900, 0);
        run_txn(0, 23'h7FFF30, 2'b11, 0, 0);
        // ready stretching and ignoring (R4)
        set_cfg(0, 1, 1, 3, 1, 1, 0, 0, 0);
        run_txn(0, 23'h000044, 2'b11, 0, 4);
        run_txn(0, 23'h000044, 2'b11, 0, 0);
        run_txn(1, 23'h000045, 2'b01, 16'h0077, 1);
        set_cfg(0, 1, 1, 3, 0, 2, 0, 0, 0);
        run_txn(0, 23'h000045, 2'b11, 0, 5);
        // segment widths (R3)
        for (int s = 0; s < 4; s++) begin
            set_cfg(s[0], 1, 1, 2'(s), 0, 0, 0, 0, 0);
            run_txn(0, 23'h7FFF50, 2'b11, 0, 0);
        end
        // random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 200 && !hung; n++) begin
            logic [1:0] be;
            be = 2'($urandom_range(1, 3));
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                    ($urandom_range(0, 9) == 0) ? 4'hF : 4'($urandom_range(0, 3)),
                    1'($urandom), 1'($urandom), 1'($urandom));
            run_txn(1'($urandom), 23'($urandom), be, 16'($urandom), $urandom_range(0, 5));
        end
        running = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule